// File: doc/BRIEF.md
# Quad-Word Link DMA Channel Pair

This block moves 128-bit quad-words between a simple synchronous memory and the two buffers of one point-to-point link port. It has a transmit channel, which reads memory and loads the link's outgoing buffer, and a receive channel, which takes the link's incoming quad-word and writes it to memory. The two channels share no state and can run in the same cycles.

Each channel is armed by a single 128-bit descriptor write. The descriptor gives the start address, a 16-bit quad-word count and a 16-bit signed address step. A separate control write then enables the channel. The control register refuses an enabling write while the channel is already running. A disabling write is always taken and aborts the channel. A channel only asks for service when its side of the link buffer is ready: the outgoing buffer must be empty, or the incoming buffer must hold a full quad-word. When the count runs out the channel stops by itself. If the descriptor asks for it, the channel gives a one-cycle done pulse.

Top module: `qlink_dma`

## Requirements
- R1: After reset both channels are idle: busy, error, irq, dreq and every memory and buffer strobe are low.
- R2: The descriptor layout is: bits 31:0 start address, bits 47:32 the signed step, bits 63:48 the count, bits 95:64 a second-dimension word, and bits 127:96 a control word whose bit 0 (descriptor bit 96) enables the done pulse. The k-th quad-word (k from 0) uses address start + k*step, modulo 2^ADDR_W. Exactly count quad-words are moved.
- R3: The step is sign-extended, so a step of 0xFFFE walks addresses downward by 2.
- R4: The transmit channel issues a memory read (tx_dreq, tx_mem_re) only while it is busy and tx_buf_empty is high. The data read is presented on tx_buf_data with tx_buf_load high in the following cycle. It issues no new read while a load is outstanding.
- R5: The receive channel writes memory (rx_dreq, rx_mem_we, rx_buf_take) only while it is busy and rx_buf_full is high. It writes rx_buf_data to memory in that same cycle, and at most one quad-word per cycle.
- R6: The transmit and receive channels run concurrently without affecting each other.
- R7: A control write with bit 0 set while the channel is busy is ignored and sets the sticky err flag. The running transfer goes on unchanged, and err stays set after the transfer ends.
- R8: A control write with bit 0 clear is always accepted. It makes the channel idle at once, discards the rest of the count, clears err, and produces no done pulse.
- R9: When the count reaches zero the channel drops busy by itself. If control bit 0 of the descriptor was set, it raises irq for exactly one cycle as it goes idle; otherwise irq stays low.
- R10: Enabling a channel whose count is zero moves no data and ends after one busy cycle, with the done pulse if it was requested.
- R11: A descriptor write while the channel is busy is ignored.
- R12: The second-dimension word has no effect; any value gives a one-dimensional transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_desc_we | input | 1 | Transmit descriptor write strobe |
| tx_desc_wdata | input | 128 | Transmit descriptor value |
| tx_ctl_we | input | 1 | Transmit control write strobe |
| tx_ctl_wdata | input | 32 | Transmit control value, bit 0 = enable |
| tx_busy | output | 1 | Transmit channel enabled and running |
| tx_err | output | 1 | Sticky refused-enable flag, transmit |
| tx_irq | output | 1 | Transmit done pulse |
| tx_dreq | output | 1 | Transmit service request |
| tx_mem_re | output | 1 | Memory read strobe |
| tx_mem_addr | output | ADDR_W | Memory read address |
| tx_mem_rdata | input | QW_W | Read data, valid the cycle after tx_mem_re |
| tx_buf_empty | input | 1 | Outgoing link buffer is empty |
| tx_buf_load | output | 1 | Load strobe for the outgoing buffer |
| tx_buf_data | output | QW_W | Quad-word for the outgoing buffer |
| rx_desc_we | input | 1 | Receive descriptor write strobe |
| rx_desc_wdata | input | 128 | Receive descriptor value |
| rx_ctl_we | input | 1 | Receive control write strobe |
| rx_ctl_wdata | input | 32 | Receive control value, bit 0 = enable |
| rx_busy | output | 1 | Receive channel enabled and running |
| rx_err | output | 1 | Sticky refused-enable flag, receive |
| rx_irq | output | 1 | Receive done pulse |
| rx_dreq | output | 1 | Receive service request |
| rx_mem_we | output | 1 | Memory write strobe |
| rx_mem_addr | output | ADDR_W | Memory write address |
| rx_mem_wdata | output | QW_W | Memory write data |
| rx_buf_full | input | 1 | Incoming link buffer holds a quad-word |
| rx_buf_data | input | QW_W | Incoming quad-word |
| rx_buf_take | output | 1 | Pops the incoming buffer |

## Verification
The bench sweeps counts 0 to 5 against positive, odd and negative steps, with the done pulse on and off. An off-by-one counter would move one quad-word too many or too few. A step that is not sign-extended would jump far up instead of walking down. It also holds each link buffer not ready after enabling. A channel that ignored buffer state would read or write memory in those cycles. The control guard is tested by re-enabling a running channel: a faulty guard restarts or lengthens the transfer, or fails to flag it. Aborts are tested by checking that no further transfers and no done pulse follow. Descriptor writes while busy are checked for the same thing: a design that took them would use the new start address.

// File: rtl/qlink_dma_pkg.sv
package qlink_dma_pkg;
   localparam int DESC_W   = 128;
   localparam int CTLW_W   = 32;
   localparam int CNT_W    = 16;
   localparam int STEP_W   = 16;
   localparam int ADDR_LSB = 0;
   localparam int STEP_LSB = 32;
   localparam int CNT_LSB  = 48;
   localparam int DIM2_LSB = 64;
   localparam int CW_LSB   = 96;
   localparam int CW_IRQ   = 0;
   localparam int CTL_EN   = 0;

   typedef struct packed {
      logic [CTLW_W-1:0] cword;
      logic [31:0]       dim2;
      logic [CNT_W-1:0]  count;
      logic [STEP_W-1:0] step;
      logic [31:0]       start;
   } qdesc_t;
endpackage

// File: rtl/qlink_ctlreg.sv
module qlink_ctlreg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_en_bit,
   input  logic fin,
   output logic en,
   output logic err,
   output logic abort
);
   assign abort = wr && !wr_en_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en  <= 1'b0;
         err <= 1'b0;
      end else if (abort) begin
         en  <= 1'b0;
         err <= 1'b0;
      end else begin
         if (wr && en) err <= 1'b1;
         if (wr && !en) en <= 1'b1;
         else if (fin)  en <= 1'b0;
      end
   end
endmodule

// File: rtl/qlink_chan.sv
module qlink_chan
   import qlink_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter bit IS_RX  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_we,
   input  logic [DESC_W-1:0] desc_wdata,
   input  logic              en,
   input  logic              abort,
   input  logic              buf_ok,
   output logic              fin,
   output logic              dreq,
   output logic              irq,
   output logic              mem_stb,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              buf_stb
);
   localparam int EXT_W = (ADDR_W > STEP_W) ? ADDR_W : STEP_W;

   qdesc_t            d_in;
   logic [ADDR_W-1:0] idx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [STEP_W-1:0] step_q;
   logic              ie_q;
   logic              pend_q;
   logic              left;
   logic [EXT_W-1:0]  step_ext;

   assign d_in     = qdesc_t'(desc_wdata);
   assign left     = (cnt_q != '0);
   assign step_ext = EXT_W'($signed(step_q));
   assign mem_addr = idx_q;
   assign irq      = fin && ie_q;

   generate
      if (IS_RX) begin : g_rx
         assign dreq    = en && left && buf_ok;
         assign buf_stb = dreq;
         assign fin     = en && !left;
         always_ff @(posedge clk) pend_q <= 1'b0;
      end else begin : g_tx
         assign dreq    = en && left && buf_ok && !pend_q;
         assign buf_stb = pend_q;
         assign fin     = en && !left && !pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= dreq;
         end
      end
   endgenerate

   assign mem_stb = dreq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         cnt_q  <= '0;
         step_q <= '0;
         ie_q   <= 1'b0;
      end else if (abort) begin
         cnt_q <= '0;
      end else if (desc_we && !en) begin
         idx_q  <= d_in.start[ADDR_W-1:0];
         cnt_q  <= d_in.count;
         step_q <= d_in.step;
         ie_q   <= d_in.cword[CW_IRQ];
      end else if (dreq) begin
         idx_q <= idx_q + step_ext[ADDR_W-1:0];
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/qlink_dma.sv
module qlink_dma
   import qlink_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int QW_W   = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_desc_we,
   input  logic [127:0]      tx_desc_wdata,
   input  logic              tx_ctl_we,
   input  logic [31:0]       tx_ctl_wdata,
   output logic              tx_busy,
   output logic              tx_err,
   output logic              tx_irq,
   output logic              tx_dreq,
   output logic              tx_mem_re,
   output logic [ADDR_W-1:0] tx_mem_addr,
   input  logic [QW_W-1:0]   tx_mem_rdata,
   input  logic              tx_buf_empty,
   output logic              tx_buf_load,
   output logic [QW_W-1:0]   tx_buf_data,
   input  logic              rx_desc_we,
   input  logic [127:0]      rx_desc_wdata,
   input  logic              rx_ctl_we,
   input  logic [31:0]       rx_ctl_wdata,
   output logic              rx_busy,
   output logic              rx_err,
   output logic              rx_irq,
   output logic              rx_dreq,
   output logic              rx_mem_we,
   output logic [ADDR_W-1:0] rx_mem_addr,
   output logic [QW_W-1:0]   rx_mem_wdata,
   input  logic              rx_buf_full,
   input  logic [QW_W-1:0]   rx_buf_data,
   output logic              rx_buf_take
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("qlink_dma: ADDR_W must lie in 1..32");
      end
      if (QW_W != 128) begin : g_bad_qw
         $error("qlink_dma: QW_W must be 128");
      end
   endgenerate

   logic tx_fin, tx_abort, rx_fin, rx_abort;

   qlink_ctlreg u_tx_ctl (
      .clk(clk), .rst_n(rst_n), .wr(tx_ctl_we), .wr_en_bit(tx_ctl_wdata[CTL_EN]),
      .fin(tx_fin), .en(tx_busy), .err(tx_err), .abort(tx_abort)
   );

   qlink_chan #(.ADDR_W(ADDR_W), .IS_RX(1'b0)) u_tx (
      .clk(clk), .rst_n(rst_n), .desc_we(tx_desc_we), .desc_wdata(tx_desc_wdata),
      .en(tx_busy), .abort(tx_abort), .buf_ok(tx_buf_empty), .fin(tx_fin),
      .dreq(tx_dreq), .irq(tx_irq), .mem_stb(tx_mem_re), .mem_addr(tx_mem_addr),
      .buf_stb(tx_buf_load)
   );

   assign tx_buf_data = tx_mem_rdata;

   qlink_ctlreg u_rx_ctl (
      .clk(clk), .rst_n(rst_n), .wr(rx_ctl_we), .wr_en_bit(rx_ctl_wdata[CTL_EN]),
      .fin(rx_fin), .en(rx_busy), .err(rx_err), .abort(rx_abort)
   );

   qlink_chan #(.ADDR_W(ADDR_W), .IS_RX(1'b1)) u_rx (
      .clk(clk), .rst_n(rst_n), .desc_we(rx_desc_we), .desc_wdata(rx_desc_wdata),
      .en(rx_busy), .abort(rx_abort), .buf_ok(rx_buf_full), .fin(rx_fin),
      .dreq(rx_dreq), .irq(rx_irq), .mem_stb(rx_mem_we), .mem_addr(rx_mem_addr),
      .buf_stb(rx_buf_take)
   );

   assign rx_mem_wdata = rx_buf_data;
endmodule

// File: rtl/qlink_dma_chk.sv
module qlink_dma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tx_ctl_we,
   input logic [31:0] tx_ctl_wdata,
   input logic        tx_busy,
   input logic        tx_err,
   input logic        tx_irq,
   input logic        tx_mem_re,
   input logic        tx_buf_empty,
   input logic        tx_buf_load,
   input logic        rx_ctl_we,
   input logic [31:0] rx_ctl_wdata,
   input logic        rx_busy,
   input logic        rx_irq,
   input logic        rx_mem_we,
   input logic        rx_buf_full
);
   a_r4_read_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mem_re |-> (tx_buf_empty && tx_busy));
   a_r4_load_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mem_re |=> (tx_buf_load && !tx_mem_re));
   a_r5_write_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mem_we |-> (rx_buf_full && rx_busy));
   a_r7_refused_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && tx_ctl_we && tx_ctl_wdata[0]) |=> tx_err);
   a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ctl_we && !tx_ctl_wdata[0]) |=> (!tx_busy && !tx_err));
   a_r8_rx_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ctl_we && !rx_ctl_wdata[0]) |=> !rx_busy);
   a_r9_tx_irq_ends: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> (!tx_irq && !tx_busy));
   a_r9_rx_irq_ends: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> (!rx_irq && !rx_busy));
endmodule

bind qlink_dma qlink_dma_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .tx_ctl_we(tx_ctl_we), .tx_ctl_wdata(tx_ctl_wdata), .tx_busy(tx_busy),
   .tx_err(tx_err), .tx_irq(tx_irq), .tx_mem_re(tx_mem_re),
   .tx_buf_empty(tx_buf_empty), .tx_buf_load(tx_buf_load),
   .rx_ctl_we(rx_ctl_we), .rx_ctl_wdata(rx_ctl_wdata), .rx_busy(rx_busy),
   .rx_irq(rx_irq), .rx_mem_we(rx_mem_we), .rx_buf_full(rx_buf_full)
);

// File: tb/tb_qlink_dma.sv
module tb_qlink_dma;
   localparam int AW = 10;
   localparam int QW = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          tx_desc_we = 0, tx_ctl_we = 0, rx_desc_we = 0, rx_ctl_we = 0;
   logic [127:0]  tx_desc_wdata = '0, rx_desc_wdata = '0;
   logic [31:0]   tx_ctl_wdata = '0, rx_ctl_wdata = '0;
   logic          tx_busy, tx_err, tx_irq, tx_dreq, tx_mem_re, tx_buf_load;
   logic          rx_busy, rx_err, rx_irq, rx_dreq, rx_mem_we, rx_buf_take;
   logic [AW-1:0] tx_mem_addr, rx_mem_addr;
   logic [QW-1:0] tx_mem_rdata = '0, tx_buf_data, rx_mem_wdata, rx_buf_data;
   logic          tx_block = 1'b0, rx_avail = 1'b1;

   int n_chk = 0, n_err = 0;
   int tx_nrd = 0, tx_nld = 0, tx_nirq = 0, rx_nwr = 0, rx_nirq = 0, rx_seq = 0;
   logic [AW-1:0] tx_ra [0:1023];
   logic [QW-1:0] tx_ld [0:1023];
   logic [AW-1:0] tx_la [0:1023];
   logic [AW-1:0] rx_wa [0:1023];
   logic [QW-1:0] rx_wd [0:1023];
   logic [AW-1:0] last_ra = '0;

   function automatic logic [QW-1:0] memval(input logic [AW-1:0] a);
      logic [31:0] w;
      w = ({22'd0, a} * 32'h0001_0003) ^ 32'hA5A5_0000;
      return {w, ~w, w + 32'd7, w ^ 32'h5A5A_5A5A};
   endfunction

   function automatic logic [QW-1:0] rxval(input int s);
      logic [31:0] w;
      w = 32'(s) * 32'h0101_0101 + 32'h1234;
      return {w ^ 32'hFFFF_0000, w, w + 32'd1, ~w};
   endfunction

   assign rx_buf_data = rxval(rx_seq);

   qlink_dma #(.ADDR_W(AW), .QW_W(QW)) dut (
      .clk(clk), .rst_n(rst_n),
      .tx_desc_we(tx_desc_we), .tx_desc_wdata(tx_desc_wdata),
      .tx_ctl_we(tx_ctl_we), .tx_ctl_wdata(tx_ctl_wdata),
      .tx_busy(tx_busy), .tx_err(tx_err), .tx_irq(tx_irq), .tx_dreq(tx_dreq),
      .tx_mem_re(tx_mem_re), .tx_mem_addr(tx_mem_addr), .tx_mem_rdata(tx_mem_rdata),
      .tx_buf_empty(!tx_block), .tx_buf_load(tx_buf_load), .tx_buf_data(tx_buf_data),
      .rx_desc_we(rx_desc_we), .rx_desc_wdata(rx_desc_wdata),
      .rx_ctl_we(rx_ctl_we), .rx_ctl_wdata(rx_ctl_wdata),
      .rx_busy(rx_busy), .rx_err(rx_err), .rx_irq(rx_irq), .rx_dreq(rx_dreq),
      .rx_mem_we(rx_mem_we), .rx_mem_addr(rx_mem_addr), .rx_mem_wdata(rx_mem_wdata),
      .rx_buf_full(rx_avail), .rx_buf_data(rx_buf_data), .rx_buf_take(rx_buf_take)
   );

   // memory, link-buffer models and monitors
   always @(posedge clk) begin
      if (rst_n) begin
         if (tx_mem_re) begin
            tx_mem_rdata <= memval(tx_mem_addr);
            tx_ra[tx_nrd & 1023] <= tx_mem_addr;
            last_ra <= tx_mem_addr;
            tx_nrd <= tx_nrd + 1;
         end
         if (tx_buf_load) begin
            tx_ld[tx_nld & 1023] <= tx_buf_data;
            tx_la[tx_nld & 1023] <= last_ra;
            tx_nld <= tx_nld + 1;
         end
         if (tx_irq) tx_nirq <= tx_nirq + 1;
         if (rx_mem_we) begin
            rx_wa[rx_nwr & 1023] <= rx_mem_addr;
            rx_wd[rx_nwr & 1023] <= rx_mem_wdata;
            rx_nwr <= rx_nwr + 1;
         end
         if (rx_buf_take) rx_seq <= rx_seq + 1;
         if (rx_irq) rx_nirq <= rx_nirq + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] mkdesc(input int base, input int cnt, input int step,
                                           input bit ie, input logic [31:0] dim2);
      return {31'd0, ie, dim2, 16'(cnt), 16'(step), 32'(base)};
   endfunction

   task automatic wr_tx_desc(input logic [127:0] d);
      @(negedge clk); tx_desc_we = 1; tx_desc_wdata = d;
      @(negedge clk); tx_desc_we = 0;
   endtask
   task automatic wr_rx_desc(input logic [127:0] d);
      @(negedge clk); rx_desc_we = 1; rx_desc_wdata = d;
      @(negedge clk); rx_desc_we = 0;
   endtask
   task automatic wr_tx_ctl(input logic [31:0] v);
      @(negedge clk); tx_ctl_we = 1; tx_ctl_wdata = v;
      @(negedge clk); tx_ctl_we = 0;
   endtask
   task automatic wr_rx_ctl(input logic [31:0] v);
      @(negedge clk); rx_ctl_we = 1; rx_ctl_wdata = v;
      @(negedge clk); rx_ctl_we = 0;
   endtask
   task automatic wait_tx_idle();
      for (int i = 0; i < 300; i++) begin
         if (!tx_busy) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask
   task automatic wait_rx_idle();
      for (int i = 0; i < 300; i++) begin
         if (!rx_busy) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   function automatic int exp_addr(input int base, input int k, input int step);
      int s;
      s = int'($signed(16'(step)));
      return (base + k * s) & ((1 << AW) - 1);
   endfunction

   task automatic check_tx(input int rd0, input int ld0, input int irq0, input int base,
                           input int cnt, input int step, input bit ie, input string tag);
      chk(tx_nrd - rd0 == cnt, {tag, " tx read count"}, tx_nrd - rd0, cnt);
      chk(tx_nld - ld0 == cnt, {tag, " tx load count"}, tx_nld - ld0, cnt);
      chk(tx_nirq - irq0 == int'(ie), {"R9 ", tag, " tx irq pulses"}, tx_nirq - irq0, ie);
      for (int k = 0; k < cnt; k++) begin
         chk(int'(tx_ra[(rd0 + k) & 1023]) == exp_addr(base, k, step), {tag, " tx address"},
             tx_ra[(rd0 + k) & 1023], exp_addr(base, k, step));
         chk(tx_ld[(ld0 + k) & 1023] == memval(tx_la[(ld0 + k) & 1023]), {tag, " tx data"},
             longint'(tx_ld[(ld0 + k) & 1023][63:0]), longint'(memval(tx_la[(ld0 + k) & 1023])[63:0]));
      end
   endtask

   task automatic check_rx(input int wr0, input int seq0, input int irq0, input int base,
                           input int cnt, input int step, input bit ie, input string tag);
      chk(rx_nwr - wr0 == cnt, {tag, " rx write count"}, rx_nwr - wr0, cnt);
      chk(rx_nirq - irq0 == int'(ie), {"R9 ", tag, " rx irq pulses"}, rx_nirq - irq0, ie);
      for (int k = 0; k < cnt; k++) begin
         chk(int'(rx_wa[(wr0 + k) & 1023]) == exp_addr(base, k, step), {tag, " rx address"},
             rx_wa[(wr0 + k) & 1023], exp_addr(base, k, step));
         chk(rx_wd[(wr0 + k) & 1023] == rxval(seq0 + k), {tag, " rx data"},
             longint'(rx_wd[(wr0 + k) & 1023][63:0]), longint'(rxval(seq0 + k)[63:0]));
      end
   endtask

   initial begin
      int rd0, ld0, i0, w0, s0, j0;
      int steps [3] = '{1, 3, 16'hFFFE};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!tx_busy && !tx_err && !tx_irq && !tx_dreq && !tx_mem_re && !tx_buf_load,
          "R1 tx idle after reset", tx_busy, 0);
      chk(!rx_busy && !rx_err && !rx_irq && !rx_dreq && !rx_mem_we && !rx_buf_take,
          "R1 rx idle after reset", rx_busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R9 R10 R12 sweep
      for (int c = 0; c <= 5; c++) begin
         for (int m = 0; m < 3; m++) begin
            automatic bit ie = c[0] ^ m[0];
            automatic logic [31:0] y = (m == 2) ? 32'h0005_0007 : 32'h0;
            automatic int base = 100 + 37 * c + m;
            rd0 = tx_nrd; ld0 = tx_nld; i0 = tx_nirq;
            wr_tx_desc(mkdesc(base, c, steps[m], ie, y));
            wr_tx_ctl(32'h1);
            wait_tx_idle();
            check_tx(rd0, ld0, i0, base, c, steps[m], ie,
                     (c == 0) ? "R10" : (m == 2) ? "R3 R12" : "R2");
            w0 = rx_nwr; s0 = rx_seq; j0 = rx_nirq;
            wr_rx_desc(mkdesc(base + 500, c, steps[m], ie, y));
            wr_rx_ctl(32'h1);
            wait_rx_idle();
            check_rx(w0, s0, j0, base + 500, c, steps[m], ie,
                     (c == 0) ? "R10" : (m == 2) ? "R3 R12" : "R2");
         end
      end

      // R4 transmit held while outgoing buffer full
      tx_block = 1; rd0 = tx_nrd; ld0 = tx_nld; i0 = tx_nirq;
      wr_tx_desc(mkdesc(40, 2, 1, 1'b1, 0));
      wr_tx_ctl(32'h1);
      repeat (5) @(negedge clk);
      chk(tx_nrd == rd0 && !tx_dreq, "R4 no read while buffer full", tx_nrd - rd0, 0);
      chk(tx_busy, "R4 still busy while held", tx_busy, 1);
      tx_block = 0;
      wait_tx_idle();
      check_tx(rd0, ld0, i0, 40, 2, 1, 1'b1, "R4");

      // R5 receive held while incoming buffer empty
      rx_avail = 0; w0 = rx_nwr; s0 = rx_seq; j0 = rx_nirq;
      wr_rx_desc(mkdesc(60, 3, 2, 1'b0, 0));
      wr_rx_ctl(32'h1);
      repeat (5) @(negedge clk);
      chk(rx_nwr == w0 && !rx_dreq, "R5 no write while buffer empty", rx_nwr - w0, 0);
      rx_avail = 1;
      wait_rx_idle();
      check_rx(w0, s0, j0, 60, 3, 2, 1'b0, "R5");

      // R6 concurrent channels
      rd0 = tx_nrd; ld0 = tx_nld; i0 = tx_nirq; w0 = rx_nwr; s0 = rx_seq; j0 = rx_nirq;
      wr_tx_desc(mkdesc(200, 4, 5, 1'b1, 0));
      wr_rx_desc(mkdesc(300, 4, 16'hFFFF, 1'b1, 0));
      @(negedge clk); tx_ctl_we = 1; tx_ctl_wdata = 1; rx_ctl_we = 1; rx_ctl_wdata = 1;
      @(negedge clk); tx_ctl_we = 0; rx_ctl_we = 0;
      chk(tx_busy && rx_busy, "R6 both busy together", {tx_busy, rx_busy}, 3);
      wait_tx_idle(); wait_rx_idle();
      check_tx(rd0, ld0, i0, 200, 4, 5, 1'b1, "R6");
      check_rx(w0, s0, j0, 300, 4, 16'hFFFF, 1'b1, "R6");

      // R7 refused enable while busy, R11 descriptor write while busy
      tx_block = 1; rd0 = tx_nrd; ld0 = tx_nld; i0 = tx_nirq;
      wr_tx_desc(mkdesc(400, 3, 2, 1'b1, 0));
      wr_tx_ctl(32'h1);
      wr_tx_ctl(32'h1);
      chk(tx_err, "R7 err set by refused enable", tx_err, 1);
      chk(tx_busy, "R7 transfer keeps running", tx_busy, 1);
      wr_tx_desc(mkdesc(700, 6, 1, 1'b0, 0));
      tx_block = 0;
      wait_tx_idle();
      check_tx(rd0, ld0, i0, 400, 3, 2, 1'b1, "R7 R11");
      chk(tx_err, "R7 err sticky after end", tx_err, 1);

      // R8 abort clears err, stops channel, no done pulse
      wr_tx_ctl(32'h0);
      chk(!tx_err && !tx_busy, "R8 disable clears err", tx_err, 0);
      tx_block = 1; rd0 = tx_nrd; i0 = tx_nirq;
      wr_tx_desc(mkdesc(10, 5, 1, 1'b1, 0));
      wr_tx_ctl(32'h1);
      wr_tx_ctl(32'h0);
      chk(!tx_busy, "R8 abort makes idle", tx_busy, 0);
      tx_block = 0;
      repeat (10) @(negedge clk);
      chk(tx_nrd == rd0, "R8 no reads after abort", tx_nrd - rd0, 0);
      chk(tx_nirq == i0, "R8 no irq after abort", tx_nirq - i0, 0);
      w0 = rx_nwr; j0 = rx_nirq; rx_avail = 0;
      wr_rx_desc(mkdesc(80, 4, 1, 1'b1, 0));
      wr_rx_ctl(32'h1);
      wr_rx_ctl(32'h0);
      rx_avail = 1;
      repeat (10) @(negedge clk);
      chk(rx_nwr == w0 && rx_nirq == j0 && !rx_busy, "R8 rx abort", rx_nwr - w0, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule